// File: doc/BRIEF.md
# Dual-Clock Sample Buffer with Overflow Capture

This block accepts results from a converter running on its own clock and stores them in a 64-entry dual-clock FIFO. Each stored result crosses into the system clock domain and is shown in a single registered output word with a valid flag. That word is drained one of two ways, picked by a mode input. In the default mode a transfer engine pulls it with a pop strobe. In the other mode the transfer engine is switched off and only CPU read strobes advance the buffer. Because the output word is just a view of the FIFO head, the CPU can keep reading after the converter has stopped until nothing is left.

The system clock must be at least as fast as the rate at which samples arrive, and faster than the converter clock. If the consumer falls behind and 64 unread results are waiting, the next sample is thrown away and the stored ones are kept. A dropped sample sets a sticky overflow flag in the system domain and fires a one-cycle interrupt pulse. The flag stays set until a write-one-to-clear strobe arrives.

Top module: `sample_xing_buffer`

## Requirements
- R1: After reset, out_valid is 0, out_empty is 1, smp_full is 0, ovf_status is 0 and ovf_irq is 0.
- R2: Every accepted sample appears on out_data exactly once, in the order it was accepted.
- R3: With no consumption, exactly 64 samples are accepted, and smp_full reads 1 in the converter clock cycle after the 64th is accepted. Unread storage never exceeds 64 entries.
- R4: A sample offered (smp_valid=1) while smp_full is 1 is discarded, and the 64 stored samples are all still delivered afterwards.
- R5: Any discarded sample sets ovf_status, which then stays 1 while ovf_clr is 0, including through later drops.
- R6: ovf_irq pulses for one system cycle when ovf_status goes from 0 to 1, and does not pulse again while it stays set.
- R7: Driving ovf_clr=1 for one system cycle, with no new drop arriving, clears ovf_status on that edge.
- R8: With xfer_off=0, a xfer_pop strobe while out_valid=1 advances to the next sample, and cpu_rd has no effect.
- R9: With xfer_off=1, a cpu_rd strobe while out_valid=1 advances to the next sample, and xfer_pop has no effect.
- R10: While no advance happens, out_data and out_valid hold. Once the buffer runs dry, out_valid is 0, out_empty is 1, and out_data keeps the last sample shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cnv_clk | input | 1 | Converter-domain clock |
| cnv_rst_n | input | 1 | Converter-domain asynchronous reset, active low |
| smp_valid | input | 1 | A new sample is offered this cycle |
| smp_data | input | DATA_W | Sample value |
| smp_full | output | 1 | Buffer full as seen from the converter domain; offered samples are dropped |
| sys_clk | input | 1 | System-domain clock |
| sys_rst_n | input | 1 | System-domain asynchronous reset, active low |
| xfer_off | input | 1 | 1 selects CPU-read draining, 0 selects transfer-engine draining |
| cpu_rd | input | 1 | CPU read strobe of the output word |
| xfer_pop | input | 1 | Transfer-engine pop strobe |
| out_data | output | DATA_W | Output data word (FIFO head) |
| out_valid | output | 1 | out_data holds an unread sample |
| out_empty | output | 1 | No unread sample is visible in the system domain |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| ovf_status | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The hardest state to reach is a buffer that is exactly full, seen from the converter domain, with the read pointer fully synchronized. Only then is the 65th sample dropped on a known edge, and not because of synchronizer lag. The stimulus stops all consumption and idles long enough for the read pointer to settle. It then offers a burst of samples with no gaps. The bench records each offered sample as dropped or accepted, based on smp_full as seen before that edge. The following CPU-mode drain then has to return exactly the 64 accepted values.

// File: rtl/sxb_pkg.sv
`timescale 1ns/1ps
package sxb_pkg;

  typedef enum logic {
    DRAIN_XFER = 1'b0,
    DRAIN_CPU  = 1'b1
  } drain_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 1; i < 32; i++) b = b ^ (g >> i);
    return b;
  endfunction

  // Entries between two pointers that wrap at 2**pw
  function automatic logic [31:0] fill_level(input logic [31:0] w, input logic [31:0] r,
                                             input int unsigned pw);
    return (w - r) & ((32'd1 << pw) - 32'd1);
  endfunction

endpackage

// File: rtl/sxb_sync2.sv
`timescale 1ns/1ps
module sxb_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sxb_wr.sv
`timescale 1ns/1ps
module sxb_wr
  import sxb_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [AW:0]   rd_gray_sync,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW:0]   wr_gray,
  output logic [AW:0]   wr_ptr,
  output logic [AW:0]   fill,
  output logic          full,
  output logic          drop,
  output logic          drop_tgl
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [PW-1:0] rd_bin;
  logic [PW-1:0] wr_next;
  logic          accept;

  assign rd_bin    = PW'(gray2bin(32'(rd_gray_sync)));
  assign fill      = PW'(fill_level(32'(wr_ptr), 32'(rd_bin), PW));
  assign full      = (fill == PW'(DEPTH));
  assign accept    = smp_valid && !full;
  assign drop      = smp_valid && full;
  assign wr_next   = wr_ptr + PW'(accept);
  assign mem_we    = accept;
  assign mem_waddr = wr_ptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      wr_gray  <= '0;
      drop_tgl <= 1'b0;
    end else begin
      wr_ptr   <= wr_next;
      wr_gray  <= PW'(bin2gray(32'(wr_next)));
      drop_tgl <= drop_tgl ^ drop;
    end
  end
endmodule

// File: rtl/sxb_rd.sv
`timescale 1ns/1ps
module sxb_rd
  import sxb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  drain_e            drain_src,
  input  logic              cpu_rd,
  input  logic              xfer_pop,
  input  logic [AW:0]       wr_gray_sync,
  input  logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     rd_addr,
  output logic [AW:0]       rd_gray,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              pop
);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] rd_bin;
  logic [PW-1:0] rd_next;
  logic [PW-1:0] wr_bin_s;
  logic          has_next;

  assign wr_bin_s = PW'(gray2bin(32'(wr_gray_sync)));
  assign pop      = out_valid && ((drain_src == DRAIN_CPU) ? cpu_rd : xfer_pop);
  assign rd_next  = rd_bin + PW'(pop);
  assign has_next = (rd_next != wr_bin_s);
  assign rd_addr  = rd_next[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin    <= '0;
      rd_gray   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      rd_bin    <= rd_next;
      rd_gray   <= PW'(bin2gray(32'(rd_next)));
      out_valid <= has_next;
      if (has_next) out_data <= rd_data;
    end
  end
endmodule

// File: rtl/sxb_ovf.sv
`timescale 1ns/1ps
module sxb_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic drop_tgl_sync,
  input  logic ovf_clr,
  output logic ovf_set,
  output logic ovf_status,
  output logic ovf_irq
);
  logic tgl_d;

  assign ovf_set = drop_tgl_sync ^ tgl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_d      <= 1'b0;
      ovf_status <= 1'b0;
      ovf_irq    <= 1'b0;
    end else begin
      tgl_d      <= drop_tgl_sync;
      ovf_status <= ovf_set || (ovf_status && !ovf_clr);
      ovf_irq    <= ovf_set && !ovf_status;
    end
  end
endmodule

// File: rtl/sample_xing_buffer.sv
`timescale 1ns/1ps
module sample_xing_buffer
  import sxb_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned DEPTH_LOG2 = 6
) (
  input  logic              cnv_clk,
  input  logic              cnv_rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              smp_full,
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              xfer_off,
  input  logic              cpu_rd,
  input  logic              xfer_pop,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_empty,
  input  logic              ovf_clr,
  output logic              ovf_status,
  output logic              ovf_irq
);
  localparam int unsigned PW    = DEPTH_LOG2 + 1;
  localparam int unsigned DEPTH = 1 << DEPTH_LOG2;

  logic [DATA_W-1:0]     mem [DEPTH];
  logic                  mem_we;
  logic [DEPTH_LOG2-1:0] mem_waddr;
  logic [DEPTH_LOG2-1:0] rd_addr;
  logic [DATA_W-1:0]     rd_data;
  logic [PW-1:0]         wr_gray, wr_gray_sync, rd_gray, rd_gray_sync;
  logic [PW-1:0]         wr_ptr, wr_fill;
  logic                  smp_drop, drop_tgl, drop_tgl_sync;
  logic                  rd_pop, ovf_set;

  sxb_wr #(.AW(DEPTH_LOG2)) u_wr (
    .clk(cnv_clk), .rst_n(cnv_rst_n), .smp_valid(smp_valid),
    .rd_gray_sync(rd_gray_sync), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .wr_gray(wr_gray), .wr_ptr(wr_ptr), .fill(wr_fill), .full(smp_full),
    .drop(smp_drop), .drop_tgl(drop_tgl)
  );

  always_ff @(posedge cnv_clk) begin
    if (mem_we) mem[mem_waddr] <= smp_data;
  end
  assign rd_data = mem[rd_addr];

  sxb_sync2 #(.W(PW)) u_sync_w2r (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(wr_gray), .q(wr_gray_sync)
  );
  sxb_sync2 #(.W(PW)) u_sync_r2w (
    .clk(cnv_clk), .rst_n(cnv_rst_n), .d(rd_gray), .q(rd_gray_sync)
  );
  sxb_sync2 #(.W(1)) u_sync_drop (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(drop_tgl), .q(drop_tgl_sync)
  );

  sxb_rd #(.DATA_W(DATA_W), .AW(DEPTH_LOG2)) u_rd (
    .clk(sys_clk), .rst_n(sys_rst_n), .drain_src(drain_e'(xfer_off)),
    .cpu_rd(cpu_rd), .xfer_pop(xfer_pop), .wr_gray_sync(wr_gray_sync),
    .rd_data(rd_data), .rd_addr(rd_addr), .rd_gray(rd_gray),
    .out_data(out_data), .out_valid(out_valid), .pop(rd_pop)
  );

  assign out_empty = !out_valid;

  sxb_ovf u_ovf (
    .clk(sys_clk), .rst_n(sys_rst_n), .drop_tgl_sync(drop_tgl_sync),
    .ovf_clr(ovf_clr), .ovf_set(ovf_set), .ovf_status(ovf_status),
    .ovf_irq(ovf_irq)
  );
endmodule

// File: rtl/sxb_chk.sv
`timescale 1ns/1ps
module sxb_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AW     = 6
) (
  input logic              cnv_clk,
  input logic              cnv_rst_n,
  input logic              sys_clk,
  input logic              sys_rst_n,
  input logic              smp_valid,
  input logic              smp_full,
  input logic [AW:0]       wr_ptr,
  input logic [AW:0]       wr_fill,
  input logic              rd_pop,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              ovf_clr,
  input logic              ovf_set,
  input logic              ovf_status,
  input logic              ovf_irq
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  assert_fill_bound_R3: assert property (@(posedge cnv_clk) disable iff (!cnv_rst_n)
    wr_fill <= PW'(DEPTH));

  assert_accept_step_R3: assert property (@(posedge cnv_clk) disable iff (!cnv_rst_n)
    smp_valid && !smp_full |=> (wr_ptr - $past(wr_ptr)) == PW'(1));

  assert_drop_no_write_R4: assert property (@(posedge cnv_clk) disable iff (!cnv_rst_n)
    smp_valid && smp_full |=> $stable(wr_ptr));

  assert_ovf_sticky_R5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    ovf_status && !ovf_clr |=> ovf_status);

  assert_irq_on_rise_R6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    ovf_irq |-> ovf_status && !$past(ovf_status));

  assert_rise_has_irq_R6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(ovf_status) |-> ovf_irq);

  assert_ovf_clear_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    ovf_clr && !ovf_set |=> !ovf_status);

  assert_out_hold_R10: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    out_valid && !rd_pop |=> out_valid && $stable(out_data));
endmodule

bind sample_xing_buffer sxb_chk #(.DATA_W(DATA_W), .AW(DEPTH_LOG2)) u_chk (
  .cnv_clk(cnv_clk), .cnv_rst_n(cnv_rst_n), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
  .smp_valid(smp_valid), .smp_full(smp_full), .wr_ptr(wr_ptr), .wr_fill(wr_fill),
  .rd_pop(rd_pop), .out_valid(out_valid), .out_data(out_data), .ovf_clr(ovf_clr),
  .ovf_set(ovf_set), .ovf_status(ovf_status), .ovf_irq(ovf_irq)
);

// File: tb/sample_xing_buffer_test.sv
`timescale 1ns/1ps
module sample_xing_buffer_test;
  logic        cnv_clk = 0, sys_clk = 0;
  logic        cnv_rst_n = 0, sys_rst_n = 0;
  logic        smp_valid = 0;
  logic [15:0] smp_data = '0;
  logic        smp_full;
  logic        xfer_off = 0, cpu_rd = 0, xfer_pop = 0, ovf_clr = 0;
  logic [15:0] out_data;
  logic        out_valid, out_empty, ovf_status, ovf_irq;

  always #4 sys_clk = ~sys_clk;   // 125 MHz
  always #7 cnv_clk = ~cnv_clk;

  sample_xing_buffer uut (
    .cnv_clk(cnv_clk), .cnv_rst_n(cnv_rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_full(smp_full), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .xfer_off(xfer_off),
    .cpu_rd(cpu_rd), .xfer_pop(xfer_pop), .out_data(out_data), .out_valid(out_valid),
    .out_empty(out_empty), .ovf_clr(ovf_clr), .ovf_status(ovf_status), .ovf_irq(ovf_irq)
  );

  // Reference model: ordered queue of accepted samples
  logic [15:0] exp_q[$];
  logic [15:0] next_val = 16'h1000;
  logic [15:0] last_out = '0;
  int checks = 0, errors = 0;
  int accepted = 0, drops = 0, pops = 0, irq_cnt = 0, cyc = 0;
  logic mode_cpu = 0, cons_on = 0;
  string tag = "R2";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Per-clock comparison and consumer (R2, R8, R9)
  always @(negedge sys_clk) begin
    if (sys_rst_n) begin
      logic m;
      logic go;
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s: actual %0h expected <nothing>", tag, out_data);
        end else if (out_data !== exp_q[0]) begin
          errors++;
          $display("FAIL %s: actual %0h expected %0h", tag, out_data, exp_q[0]);
        end
      end
      if (ovf_irq) irq_cnt++;
      m = mode_cpu;
      cyc++;
      xfer_off = m;
      cpu_rd   = cons_on && (cyc % 3 != 1);
      xfer_pop = cons_on && (cyc % 2 == 0);
      go = m ? cpu_rd : xfer_pop;
      if (out_valid && go && exp_q.size() > 0) begin
        last_out = exp_q.pop_front();
        pops++;
      end
    end
  end

  task automatic push(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge cnv_clk);
      smp_valid = 1;
      smp_data  = next_val;
      if (smp_full) drops++;
      else begin
        exp_q.push_back(next_val);
        accepted++;
      end
      next_val++;
      for (int g = 0; g < gap; g++) begin
        @(negedge cnv_clk);
        smp_valid = 0;
      end
    end
    @(negedge cnv_clk);
    smp_valid = 0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 5000 && exp_q.size() != 0; i++) @(negedge sys_clk);
    repeat (6) @(negedge sys_clk);
  endtask

  initial begin
    repeat (150000) @(posedge sys_clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] first_c;
    int d0, p0;
    repeat (5) @(negedge sys_clk);
    cnv_rst_n = 1;
    sys_rst_n = 1;
    @(negedge sys_clk);
    // R1: reset state
    chk("R1", out_valid, 0);
    chk("R1", out_empty, 1);
    chk("R1", smp_full, 0);
    chk("R1", ovf_status, 0);
    chk("R1", ovf_irq, 0);

    // R8: transfer-engine draining, cpu_rd toggling but ignored
    tag = "R8"; mode_cpu = 0; cons_on = 1;
    push(30, 0);
    push(10, 3);
    wait_drain();
    chk("R10", out_empty, 1);
    chk("R10", out_data, last_out);

    // R9: CPU draining, xfer_pop toggling but ignored
    cons_on = 0;
    repeat (3) @(negedge sys_clk);
    mode_cpu = 1;
    repeat (3) @(negedge sys_clk);
    tag = "R9"; cons_on = 1;
    push(30, 1);
    wait_drain();
    chk("R9", pops, accepted);

    // R3 / R4: fill with no consumer, then overflow
    cons_on = 0;
    tag = "R4";
    repeat (20) @(negedge sys_clk);
    first_c = next_val;
    d0 = drops;
    push(64, 0);
    chk("R3", smp_full, 1);
    chk("R3", drops - d0, 0);
    repeat (8) @(negedge sys_clk);
    chk("R10", out_valid, 1);
    chk("R10", out_data, first_c);
    push(6, 0);
    chk("R4", drops - d0, 6);
    repeat (10) @(negedge sys_clk);
    chk("R5", ovf_status, 1);
    chk("R6", irq_cnt, 1);
    push(2, 0);
    repeat (10) @(negedge sys_clk);
    chk("R5", ovf_status, 1);
    chk("R6", irq_cnt, 1);
    chk("R4", exp_q.size(), 64);

    // Drain after the converter has stopped
    p0 = pops;
    cons_on = 1;
    wait_drain();
    cons_on = 0;
    chk("R4", pops - p0, 64);
    chk("R10", out_empty, 1);
    chk("R10", out_data, 32'(first_c) + 63);
    chk("R5", ovf_status, 1);

    // R7: write-one-to-clear
    @(negedge sys_clk);
    ovf_clr = 1;
    @(negedge sys_clk);
    ovf_clr = 0;
    chk("R7", ovf_status, 0);

    chk("R2", exp_q.size(), 0);
    chk("R2", pops, accepted);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule